// File: doc/BRIEF.md
# Gray-Scale Line Latch and Column Drive Selector

This block produces the drive-level selection for every column of one display row. Each line strobe fetches a whole row of 2-bit pixels from display memory into a fetch latch. On the following strobe that row moves into a hold latch, which feeds the outputs. The next row can therefore load while the current row is on the panel. A frame-modulation decoder turns each 2-bit gray value into an on or off state that depends on the frame phase. The state is then mapped onto one of three drive levels. A polarity bit swaps the on and off levels from frame to frame.

A line counter supplies the row address to the display memory and wraps once per frame. On each wrap a modulo-3 phase counter advances and the polarity bit toggles. Each row carries the phase and polarity of the frame in which it was fetched. The hold latch uses that frame's phase and polarity even after the counters have moved on. An active-low blanking input forces every column to the middle level at once. Level shifting and the analog drive stages lie outside this block.

Top module: `gray_line_drive`

## Requirements
- R1: After reset the row address is 0, the phase is 0, the polarity is 0 and every column drives code 0 (V0).
- R2: Each strobe advances `rd_line_o` by one. It wraps from NLINE-1 to 0 and does not change without a strobe.
- R3: On each wrap strobe the phase steps 0→1→2→0 and the polarity toggles. Neither changes on any other cycle.
- R4: The row whose address is on `rd_line_o` at a strobe reaches `drive_o` after the following strobe. Column c takes its pixel from bits [2c+1:2c] of `rd_data_i`.
- R5: `drive_o` changes only on the cycle after a strobe, or when blanking changes. Changes of `rd_data_i` between strobes have no effect.
- R6: Gray value 0 is off in every phase and gray value 3 is on in every phase.
- R7: Gray value 1 is on only in phase 0. Gray value 2 is on in phases 0 and 1 and off in phase 2.
- R8: Level codes are 0=V0, 1=V1, 2=V2. With polarity 0 an on pixel drives V2 and an off pixel drives V0. With polarity 1 the two are swapped.
- R9: While `blank_n_i` is low every column drives V1 in the same cycle. Releasing it restores the decoded levels.
- R10: Code 3 never appears on any column.
- R11: A row is decoded with the phase and polarity that held when it was fetched. This also applies to the last row of a frame, which is shown after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strobe_i | input | 1 | Line strobe, one cycle wide |
| blank_n_i | input | 1 | Active-low blanking, forces every column to V1 |
| rd_line_o | output | $clog2(NLINE) | Row address to display memory; also the line counter |
| rd_data_i | input | 2*NCOL | Pixel row from memory; column c at [2c+1:2c] |
| drive_o | output | 2*NCOL | Drive level code per column; column c at [2c+1:2c] |
| phase_o | output | 2 | Frame modulation phase, 0 to 2 |
| polarity_o | output | 1 | Frame polarity |

## Verification
The bench uses an 8-column, 6-line configuration. The memory row is built so that every gray value appears in every row. A per-frame offset shifts the values, so each value meets each phase under both polarities over seven frames. This separates faults in the gray-to-on pattern from faults in the polarity swap. It also shows whether a column's bits land in the right field. The memory contents are changed between strobes so that a design which passes fetch data through to the outputs can be told apart from one that holds the row. Blanking pulses on different lines check the override and its release. The strobe after the wrap tests whether the shown row keeps the phase and polarity of its own frame.

// File: rtl/gls_pkg.sv
package gls_pkg;

  typedef enum logic [1:0] {
    DRV_V0 = 2'd0,
    DRV_V1 = 2'd1,
    DRV_V2 = 2'd2
  } drive_e;

  // frame context carried alongside a fetched row
  typedef struct packed {
    logic [1:0] phase;
    logic       pol;
  } frame_tag_t;

  localparam int PHASES = 3;

  // gray value to on/off for a given modulation phase
  function automatic logic gray_on(input logic [1:0] gray, input logic [1:0] phase);
    logic on;
    case (gray)
      2'd0:    on = 1'b0;
      2'd1:    on = (phase == 2'd0);
      2'd2:    on = (phase != 2'd2);
      default: on = 1'b1;
    endcase
    return on;
  endfunction

endpackage

// File: rtl/gls_frame_seq.sv
module gls_frame_seq #(
  parameter int NLINE  = 240,
  parameter int LINE_W = $clog2(NLINE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  output logic [LINE_W-1:0] line_o,
  output logic [1:0]        phase_o,
  output logic              pol_o
);
  import gls_pkg::*;

  localparam logic [LINE_W-1:0] LAST_LINE  = LINE_W'(NLINE - 1);
  localparam logic [1:0]        LAST_PHASE = 2'(PHASES - 1);

  logic [LINE_W-1:0] line_q, line_d;
  logic [1:0]        phase_q, phase_d;
  logic              pol_q, pol_d;
  logic              wrap;

  always_comb begin
    wrap    = adv_i && (line_q == LAST_LINE);
    line_d  = line_q;
    phase_d = phase_q;
    pol_d   = pol_q;
    if (adv_i) begin
      line_d = wrap ? '0 : line_q + LINE_W'(1);
    end
    if (wrap) begin
      phase_d = (phase_q == LAST_PHASE) ? 2'd0 : phase_q + 2'd1;
      pol_d   = ~pol_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      phase_q <= 2'd0;
      pol_q   <= 1'b0;
    end else if (adv_i) begin
      line_q  <= line_d;
      phase_q <= phase_d;
      pol_q   <= pol_d;
    end
  end

  assign line_o  = line_q;
  assign phase_o = phase_q;
  assign pol_o   = pol_q;

endmodule

// File: rtl/gls_latch_pair.sv
module gls_latch_pair #(
  parameter int W = 320
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [W-1:0]        data_i,
  input  gls_pkg::frame_tag_t tag_i,
  output logic [W-1:0]        data_o,
  output gls_pkg::frame_tag_t tag_o
);
  import gls_pkg::*;

  // stage 1: fetch latch, stage 2: hold latch feeding the decoder
  logic [W-1:0] fetch_q, fetch_d, hold_q, hold_d;
  frame_tag_t   ftag_q, ftag_d, htag_q, htag_d;

  always_comb begin
    fetch_d = fetch_q;
    ftag_d  = ftag_q;
    hold_d  = hold_q;
    htag_d  = htag_q;
    if (load_i) begin
      hold_d  = fetch_q;
      htag_d  = ftag_q;
      fetch_d = data_i;
      ftag_d  = tag_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= '0;
      hold_q  <= '0;
      ftag_q  <= '0;
      htag_q  <= '0;
    end else if (load_i) begin
      fetch_q <= fetch_d;
      hold_q  <= hold_d;
      ftag_q  <= ftag_d;
      htag_q  <= htag_d;
    end
  end

  assign data_o = hold_q;
  assign tag_o  = htag_q;

endmodule

// File: rtl/gls_gray_decode.sv
module gls_gray_decode #(
  parameter int NCOL = 160,
  parameter int W    = 2 * NCOL
) (
  input  logic [W-1:0]        pix_i,
  input  gls_pkg::frame_tag_t tag_i,
  input  logic                blank_n_i,
  output logic [W-1:0]        drive_o
);
  import gls_pkg::*;

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic   on;
    drive_e lvl;
    always_comb begin
      on = gray_on(pix_i[2*c +: 2], tag_i.phase);
      if (!blank_n_i) begin
        lvl = DRV_V1;
      end else if (on ^ tag_i.pol) begin
        lvl = DRV_V2;
      end else begin
        lvl = DRV_V0;
      end
    end
    assign drive_o[2*c +: 2] = lvl;
  end

endmodule

// File: rtl/gray_line_drive.sv
module gray_line_drive #(
  parameter int NCOL   = 160,
  parameter int NLINE  = 240,
  parameter int LINE_W = $clog2(NLINE),
  parameter int W      = 2 * NCOL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic              blank_n_i,
  output logic [LINE_W-1:0] rd_line_o,
  input  logic [W-1:0]      rd_data_i,
  output logic [W-1:0]      drive_o,
  output logic [1:0]        phase_o,
  output logic              polarity_o
);
  import gls_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [1:0]   phase;
  logic         pol_q;
  frame_tag_t   cur_tag, show_tag;
  logic [W-1:0] show_pix;

  gls_frame_seq #(.NLINE(NLINE), .LINE_W(LINE_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_q),
    .adv_i   (strobe_i),
    .line_o  (rd_line_o),
    .phase_o (phase),
    .pol_o   (pol_q)
  );

  assign cur_tag = '{phase: phase, pol: pol_q};

  gls_latch_pair #(.W(W)) u_latch (
    .clk    (clk),
    .rst_n  (rst_q),
    .load_i (strobe_i),
    .data_i (rd_data_i),
    .tag_i  (cur_tag),
    .data_o (show_pix),
    .tag_o  (show_tag)
  );

  gls_gray_decode #(.NCOL(NCOL), .W(W)) u_dec (
    .pix_i     (show_pix),
    .tag_i     (show_tag),
    .blank_n_i (blank_n_i),
    .drive_o   (drive_o)
  );

  assign phase_o    = phase;
  assign polarity_o = pol_q;

endmodule

// File: rtl/gls_chk.sv
module gls_chk #(
  parameter int NCOL   = 160,
  parameter int NLINE  = 240,
  parameter int LINE_W = $clog2(NLINE),
  parameter int W      = 2 * NCOL
) (
  input logic              clk,
  input logic              rst_q,
  input logic              strobe_i,
  input logic              blank_n_i,
  input logic [LINE_W-1:0] rd_line_o,
  input logic [W-1:0]      drive_o,
  input logic [1:0]        phase_o,
  input logic              polarity_o
);
  localparam logic [LINE_W-1:0] LAST = LINE_W'(NLINE - 1);

  logic any_code3, all_mid;
  always_comb begin
    any_code3 = 1'b0;
    all_mid   = 1'b1;
    for (int c = 0; c < NCOL; c++) begin
      if (drive_o[2*c +: 2] == 2'd3) any_code3 = 1'b1;
      if (drive_o[2*c +: 2] != 2'd1) all_mid   = 1'b0;
    end
  end

  logic wrap_now;
  assign wrap_now = strobe_i && (rd_line_o == LAST);

  // R2
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_q)
    strobe_i |=> rd_line_o == (($past(rd_line_o) == LAST) ? '0 : $past(rd_line_o) + LINE_W'(1)));

  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !strobe_i |=> $stable(rd_line_o));

  // R3
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_q)
    wrap_now |=> (phase_o == (($past(phase_o) == 2'd2) ? 2'd0 : $past(phase_o) + 2'd1))
                 && (polarity_o != $past(polarity_o)));

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !wrap_now |=> $stable(phase_o) && $stable(polarity_o));

  // R5
  drive_stable_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!strobe_i && blank_n_i) |=> (!blank_n_i || $stable(drive_o)));

  // R9
  blank_mid_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !blank_n_i |-> all_mid);

  // R10
  no_code3_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !any_code3);

endmodule

bind gray_line_drive gls_chk #(.NCOL(NCOL), .NLINE(NLINE), .LINE_W(LINE_W), .W(W)) u_chk (
  .clk        (clk),
  .rst_q      (rst_q),
  .strobe_i   (strobe_i),
  .blank_n_i  (blank_n_i),
  .rd_line_o  (rd_line_o),
  .drive_o    (drive_o),
  .phase_o    (phase_o),
  .polarity_o (polarity_o)
);

// File: tb/test_gray_line_drive.sv
module test_gray_line_drive;
  localparam int NCOL   = 8;
  localparam int NLINE  = 6;
  localparam int LINE_W = $clog2(NLINE);
  localparam int W      = 2 * NCOL;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              strobe;
  logic              blank_n;
  logic [LINE_W-1:0] rd_line;
  logic [W-1:0]      rd_data;
  logic [W-1:0]      drive;
  logic [1:0]        phase;
  logic              pol;

  int seed = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gray_line_drive #(.NCOL(NCOL), .NLINE(NLINE)) i_gray_line_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_i   (strobe),
    .blank_n_i  (blank_n),
    .rd_line_o  (rd_line),
    .rd_data_i  (rd_data),
    .drive_o    (drive),
    .phase_o    (phase),
    .polarity_o (pol)
  );

  // memory row: pixel c of row l = (l + c + s) mod 4
  function automatic logic [W-1:0] ram_row(input int l, input int s);
    logic [W-1:0] r;
    for (int c = 0; c < NCOL; c++) r[2*c +: 2] = 2'((l + c + s) % 4);
    return r;
  endfunction

  always_comb rd_data = ram_row(int'(rd_line), seed);

  // expected levels from R6, R7, R8, R9
  function automatic logic [W-1:0] exp_drive(input logic [W-1:0] px, input int ph,
                                             input bit p, input bit bn);
    logic [W-1:0] r;
    for (int c = 0; c < NCOL; c++) begin
      int  g;
      bit  on;
      g  = int'(px[2*c +: 2]);
      on = (g == 3) || (g == 2 && ph != 2) || (g == 1 && ph == 0);
      if (!bn)          r[2*c +: 2] = 2'd1;
      else if (on != p) r[2*c +: 2] = 2'd2;
      else              r[2*c +: 2] = 2'd0;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench model state
  int           m_line = 0, m_ph = 0;
  bit           m_pol = 0;
  logic [W-1:0] m_l1 = '0, m_l2 = '0;
  int           m_ph1 = 0, m_ph2 = 0;
  bit           m_pol1 = 0, m_pol2 = 0;

  task automatic do_strobe();
    @(negedge clk);
    strobe = 1'b1;
    m_l2 = m_l1; m_ph2 = m_ph1; m_pol2 = m_pol1;
    m_l1 = ram_row(m_line, seed); m_ph1 = m_ph; m_pol1 = m_pol;
    if (m_line == NLINE - 1) begin
      m_line = 0;
      m_ph   = (m_ph + 1) % 3;
      m_pol  = !m_pol;
    end else begin
      m_line = m_line + 1;
    end
    @(negedge clk);
    strobe = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; strobe = 1'b0; blank_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(rd_line == '0 && phase == 2'd0 && pol == 1'b0, "R1 counters",
        W'({rd_line, phase, pol}), '0);
    chk(drive == '0, "R1 drive", drive, '0);
    // R9 right after reset
    blank_n = 1'b0; #1;
    chk(drive == exp_drive(m_l2, 0, 0, 0), "R9 blank", drive, exp_drive(m_l2, 0, 0, 0));
    blank_n = 1'b1; #1;

    for (int fr = 0; fr < 7; fr++) begin
      seed = fr;
      for (int ln = 0; ln < NLINE; ln++) begin
        bit was_wrap;
        logic [W-1:0] e;
        was_wrap = (m_line == NLINE - 1);
        do_strobe();
        // R2, R3
        chk(int'(rd_line) == m_line, "R2 line", W'(rd_line), W'(m_line));
        chk(int'(phase) == m_ph && pol == m_pol, "R3 phase/polarity",
            W'({phase, pol}), W'({m_ph[1:0], m_pol}));
        // R4 R6 R7 R8 R10 (R11 on wrap)
        e = exp_drive(m_l2, m_ph2, m_pol2, 1'b1);
        chk(drive == e, was_wrap ? "R11 wrap row" : "R4 R6 R7 R8 decode", drive, e);
        // R5: disturb memory between strobes
        seed = fr + 1 + ln;
        repeat (2) @(negedge clk);
        chk(drive == e, "R5 hold", drive, e);
        seed = fr;
        // R9 blanking pulse
        if ((ln + fr) % 3 == 0) begin
          blank_n = 1'b0; #1;
          chk(drive == exp_drive(m_l2, m_ph2, m_pol2, 1'b0), "R9 blank", drive,
              exp_drive(m_l2, m_ph2, m_pol2, 1'b0));
          @(negedge clk);
          blank_n = 1'b1; #1;
          chk(drive == e, "R9 release", drive, e);
        end
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule